// File: doc/BRIEF.md
# Basic-mode parallel I/O port group

This block provides three byte-wide general purpose I/O ports, called A, B and C, behind a four-location host register window. Each port works in plain level mode, with no strobes and no handshake. A host writes a port's data location to set its output latch. It writes the control location to pick a direction for each of four sections: port A, port B, the low nibble of port C and the high nibble of port C. Reading a data location returns the latched value on output bits and the live pin level on input bits.

Four board-level force straps can pin any section to output, whatever software writes. A retain strap decides what a synchronous warm reset does. With the strap set, directions and latches ride through the warm reset unchanged. With it clear, the warm reset behaves like the asynchronous power-on reset: every section becomes an input and every latch becomes zero.

Top module: `pio_group`

## Requirements
- R1: While `rst_n` is low, and after it is released, the control readback is 0, `pin_oe` is all zero and `pin_out` is all zero. This holds even when `retain_en` is 1.
- R2: A write to offset 3 stores `wr_data[3:0]` as the direction bits, with 1 meaning output. Bit 0 controls `pin_oe[7:0]` (port A), bit 1 controls `pin_oe[15:8]` (port B), bit 2 controls `pin_oe[19:16]` (C low) and bit 3 controls `pin_oe[23:20]` (C high). Every `pin_oe` bit of a section equals that section's effective direction.
- R3: When `force_out[i]` is 1, section i is an output whatever its stored direction bit holds. Reading offset 3 returns the effective direction (stored OR forced) in bits 3:0, with bits 7:4 reading zero.
- R4: A write to offset 0, 1 or 2 loads the latch of port A, B or C respectively, whatever the port's direction. `pin_out` always carries the latches as {C, B, A}.
- R5: A read of offset 0, 1 or 2 returns, per bit, the latch where the section is an output and the matching `pin_in` bit where it is an input. The read is combinational from `addr` in the same cycle.
- R6: A warm reset with `retain_en` = 1 leaves the directions and all three latches exactly as they were. A write presented in the same cycle is dropped.
- R7: A warm reset with `retain_en` = 0 clears the directions to input and the latches to zero. A write presented in the same cycle is dropped.
- R8: A cycle with `wr_en` low changes no direction and no latch, whatever `addr` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| retain_en | input | 1 | Strap: keep state across a warm reset |
| force_out | input | 4 | Straps forcing A, B, C-low, C-high to output |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| pin_in | input | 24 | Pin levels {C, B, A} |
| pin_out | output | 24 | Output latches {C, B, A} |
| pin_oe | output | 24 | Per-pin output enable |

## Verification
The bench mixes random writes, idle strobes, strap changes and warm resets of both kinds, and checks every output and all four readbacks after each step. It goes after the following cases:
- Port C split into nibbles. A design that treats port C as one byte would drive or sample all eight C pins together.
- A forced section whose stored bit is 0. A design that ignores the force strap there would report an input, or read back pin levels instead of the latch.
- A write colliding with a warm reset. A design that lets the write through would corrupt retained state.
- A power-on reset with `retain_en` high. A design that honours the strap on power-on reset would fail to clear.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PORT_W  = 8;
    localparam int HALF_W  = PORT_W / 2;
    localparam int NSEC    = 4;
    localparam int ADDR_W  = 2;
    localparam int PIN_W   = 3 * PORT_W;
    localparam logic [ADDR_W-1:0] OFS_A   = 2'd0;
    localparam logic [ADDR_W-1:0] OFS_B   = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_C   = 2'd2;
    localparam logic [ADDR_W-1:0] OFS_CFG = 2'd3;

    typedef struct packed {
        logic [NSEC-1:0]   dir;
        logic [PORT_W-1:0] lat_c;
        logic [PORT_W-1:0] lat_b;
        logic [PORT_W-1:0] lat_a;
    } pio_state_t;

    // Expand four section direction bits to a per-pin mask {C, B, A}.
    function automatic logic [PIN_W-1:0] dir_mask(input logic [NSEC-1:0] d);
        return {{HALF_W{d[3]}}, {HALF_W{d[2]}}, {PORT_W{d[1]}}, {PORT_W{d[0]}}};
    endfunction
endpackage

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              retain_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output pio_state_t        st
);
    pio_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (warm_rst) begin
            if (!retain_en) st_d = '0;
        end else if (wr_en) begin
            case (addr)
                OFS_A:   st_d.lat_a = wr_data;
                OFS_B:   st_d.lat_b = wr_data;
                OFS_C:   st_d.lat_c = wr_data;
                default: st_d.dir   = wr_data[NSEC-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    a_r6_retain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst && retain_en) |=> (st_q == $past(st_q)));

    a_r7_warm_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_rst && !retain_en) |=> (st_q == '0));

    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !warm_rst) |=> $stable(st_q));

    a_r4_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !warm_rst && addr == OFS_B) |=> (st_q.lat_b == $past(wr_data)));
endmodule

// File: rtl/pio_pins.sv
module pio_pins
    import pio_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  pio_state_t      st,
    input  logic [NSEC-1:0] force_out,
    output logic [NSEC-1:0] eff_dir,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe
);
    assign eff_dir = st.dir | force_out;
    assign pin_out = {st.lat_c, st.lat_b, st.lat_a};

    localparam int SEC_LO [NSEC] = '{0, PORT_W, 2*PORT_W, 2*PORT_W + HALF_W};
    localparam int SEC_W  [NSEC] = '{PORT_W, PORT_W, HALF_W, HALF_W};

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        assign pin_oe[SEC_LO[s] +: SEC_W[s]] = {SEC_W[s]{eff_dir[s]}};
    end

    a_r3_force_a: assert property (@(posedge clk) disable iff (!rst_n)
        force_out[0] |-> (&pin_oe[PORT_W-1:0]));

    a_r3_force_chi: assert property (@(posedge clk) disable iff (!rst_n)
        force_out[3] |-> (&pin_oe[PIN_W-1:PIN_W-HALF_W]));

    a_r2_c_lo_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pin_oe[2*PORT_W +: HALF_W]) == 0) ||
        ($countones(pin_oe[2*PORT_W +: HALF_W]) == HALF_W));
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
(
    input  pio_state_t        st,
    input  logic [NSEC-1:0]   eff_dir,
    input  logic [PIN_W-1:0]  pin_in,
    input  logic [ADDR_W-1:0] addr,
    output logic [PORT_W-1:0] rd_data
);
    logic [PIN_W-1:0] mask, merged;

    always_comb begin
        mask   = dir_mask(eff_dir);
        merged = ({st.lat_c, st.lat_b, st.lat_a} & mask) | (pin_in & ~mask);
        case (addr)
            OFS_A:   rd_data = merged[0 +: PORT_W];
            OFS_B:   rd_data = merged[PORT_W +: PORT_W];
            OFS_C:   rd_data = merged[2*PORT_W +: PORT_W];
            default: rd_data = {{(PORT_W-NSEC){1'b0}}, eff_dir};
        endcase
    end

    always_comb begin
        if (addr == OFS_CFG) a_r3_cfg_upper_zero: assert (rd_data[PORT_W-1:NSEC] == '0);
    end
endmodule

// File: rtl/pio_group.sv
module pio_group
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              retain_en,
    input  logic [NSEC-1:0]   force_out,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    pio_state_t      st;
    logic [NSEC-1:0] eff_dir;

    pio_regs u_regs (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .retain_en(retain_en),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .st(st)
    );

    pio_pins u_pins (
        .clk(clk), .rst_n(rst_n), .st(st), .force_out(force_out),
        .eff_dir(eff_dir), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    pio_rdmux u_rd (
        .st(st), .eff_dir(eff_dir), .pin_in(pin_in), .addr(addr), .rd_data(rd_data)
    );

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (pin_oe == (pin_oe & dir_mask(force_out))) && (pin_out == '0));
endmodule

// File: tb/tb_pio_group.sv
module tb_pio_group;
    import pio_pkg::*;

    logic clk = 0, rst_n = 0, warm_rst = 0, retain_en = 0, wr_en = 0;
    logic [NSEC-1:0]   force_out = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [PORT_W-1:0] wr_data = '0, rd_data;
    logic [PIN_W-1:0]  pin_in = '0, pin_out, pin_oe;

    int n_chk = 0, n_err = 0;
    logic [NSEC-1:0]   m_dir;
    logic [PORT_W-1:0] m_a, m_b, m_c;

    always #4 clk = ~clk;

    pio_group dut (.*);

    function automatic logic [PIN_W-1:0] exp_mask();
        logic [NSEC-1:0] d = m_dir | force_out;
        return {{HALF_W{d[3]}}, {HALF_W{d[2]}}, {PORT_W{d[1]}}, {PORT_W{d[0]}}};
    endfunction

    function automatic logic [PORT_W-1:0] exp_rd(input logic [ADDR_W-1:0] a);
        logic [PIN_W-1:0] mk = exp_mask();
        logic [PIN_W-1:0] mg = ({m_c, m_b, m_a} & mk) | (pin_in & ~mk);
        case (a)
            2'd0:    return mg[7:0];
            2'd1:    return mg[15:8];
            2'd2:    return mg[23:16];
            default: return {4'b0, m_dir | force_out};
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(pin_oe == exp_mask(), {tag, " R2 R3 pin_oe"}, 32'(pin_oe), 32'(exp_mask()));
        check(pin_out == {m_c, m_b, m_a}, {tag, " R4 pin_out"}, 32'(pin_out), 32'({m_c, m_b, m_a}));
        for (int a = 0; a < 4; a++) begin
            addr = ADDR_W'(a);
            pin_in = PIN_W'($urandom);
            #1;
            check(rd_data == exp_rd(addr), {tag, " R5 R3 readback"}, 32'(rd_data), 32'(exp_rd(addr)));
        end
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [PORT_W-1:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1;
        @(negedge clk);
        wr_en = 0;
        case (a)
            2'd0:    m_a = d;
            2'd1:    m_b = d;
            2'd2:    m_c = d;
            default: m_dir = d[3:0];
        endcase
    endtask

    task automatic do_warm(input logic keep, input logic collide);
        @(negedge clk);
        warm_rst = 1; retain_en = keep;
        wr_en = collide; addr = ADDR_W'($urandom); wr_data = PORT_W'($urandom);
        @(negedge clk);
        warm_rst = 0; wr_en = 0;
        if (!keep) begin m_dir = '0; m_a = '0; m_b = '0; m_c = '0; end
    endtask

    task automatic do_idle();
        @(negedge clk);
        addr = ADDR_W'($urandom); wr_data = PORT_W'($urandom); wr_en = 0;
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        m_dir = '0; m_a = '0; m_b = '0; m_c = '0;
        retain_en = 1;
        repeat (3) @(negedge clk);
        check_all("R1 during reset");
        rst_n = 1;
        @(negedge clk);
        check_all("R1 after reset");

        // R2: C nibbles independent
        do_write(2'd3, 8'hF4);
        do_write(2'd2, 8'h5A);
        check_all("R2 C low only");
        do_write(2'd3, 8'h08);
        check_all("R2 C high only");
        // R3: forced section with stored bit 0 reads latch
        force_out = 4'b0001;
        do_write(2'd0, 8'hC3);
        check_all("R3 forced A");
        // R8: idle cycle
        do_idle();
        check_all("R8 idle");
        // R6: retain with colliding write
        do_write(2'd1, 8'h99);
        do_warm(1'b1, 1'b1);
        check_all("R6 retain collide");
        // R7: clear with colliding write
        do_warm(1'b0, 1'b1);
        check_all("R7 clear collide");

        for (int i = 0; i < 400; i++) begin
            case ($urandom % 8)
                0, 1, 2, 3: do_write(ADDR_W'($urandom), PORT_W'($urandom));
                4:          do_idle();
                5:          begin force_out = NSEC'($urandom); @(negedge clk); end
                6:          do_warm(1'($urandom), 1'($urandom));
                default:    do_write(2'd3, PORT_W'($urandom));
            endcase
            check_all("random R4 R5 R6 R7 R8");
        end

        // R1: power-on reset clears even with retain strap set
        force_out = '0;
        do_write(2'd3, 8'h0F);
        do_write(2'd0, 8'hAA);
        retain_en = 1;
        @(negedge clk); rst_n = 0;
        m_dir = '0; m_a = '0; m_b = '0; m_c = '0;
        @(negedge clk);
        check_all("R1 por with retain");
        rst_n = 1;
        @(negedge clk);
        check_all("R1 por released");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule